// File: doc/BRIEF.md
# Watchdog / Countdown Tick Timer

A programmable down-counter that advances on one of several externally prescaled tick strobes. A two-bit mode field chooses between stopped, periodic countdown and one-shot watchdog operation. Software reloads the counter by writing the count register, and each selected tick decrements it. In countdown mode an expiry reloads the counter and raises a countdown flag that software clears by writing. In watchdog mode an expiry parks the counter at zero and raises a read-only watchdog flag that clears itself when the status register is read.

Each flag has its own enable. The enabled flags drive one interrupt output. That output either follows the enabled flags as a level or produces a fixed-length pulse on each enabled expiry event. All access goes through a small four-address register port with single-cycle write and read strobes. Read data is combinational and shows the state before any clear-on-read takes effect.

Top module: `tick_watchdog`

## Requirements
- R1: After the active-low asynchronous reset, every register reads 0, the counter is 0 and irq_o is 0.
- R2: The mode field is bits 2:1 of the control register (address 0). Code 01 is countdown and 10 is watchdog. Codes 00 and 11 stop the timer, and while stopped, ticks leave the count unchanged.
- R3: Bits SRC_W-1:0 of the source register (address 1) select which tick_i line advances the counter. Code 010 is the line wired to the 1 Hz strobe. Ticks on any other line are ignored.
- R4: Writing the count register (address 2) loads both the reload value and the counter, and ends a watchdog halt. Reading address 2 returns the current count in bits CNT_W-1:0. Each selected tick decrements the counter by one. A loaded value N expires on the Nth tick, and N = 0 expires on tick 2^CNT_W.
- R5: In countdown mode an expiry reloads the counter with the last written value, sets the countdown flag (status bit 6) and keeps counting.
- R6: In watchdog mode an expiry leaves the counter at 0, sets the watchdog flag (status bit 7) and halts. Later ticks have no effect until the count register is written again.
- R7: The watchdog flag ignores writes and clears on the clock edge that ends a read of the status register (address 3).
- R8: If a watchdog expiry coincides with a status read, the flag is left set.
- R9: Writing the status register with bit 6 = 0 clears the countdown flag, and writing bit 6 = 1 leaves it unchanged.
- R10: Status bit 2 enables the watchdog interrupt and bit 1 enables the countdown interrupt. With control bit 7 = 0, irq_o is high while any enabled flag is set.
- R11: With control bit 7 = 1, each expiry whose enable is set drives irq_o high for exactly PULSE_LEN clocks, starting on the edge of the expiry. The pulse length does not depend on when the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (drives clear-on-read) |
| reg_addr_i | input | 2 | Register address: 0 control, 1 source, 2 count, 3 status |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| tick_i | input | 2**SRC_W | Prescaled single-cycle tick strobes |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench builds the block with CNT_W = 4, SRC_W = 3 and PULSE_LEN = 3. At that width every load value, including 0 (the full 16-tick span), can be run in both countdown and watchdog modes, and the count can be checked after every tick. All eight tick lines are exercised against the selected source. The short pulse makes it practical to check the pulse length exactly and to show that it is independent of clearing the flag. Corner cases are also driven directly: a status read in the same cycle as an expiry, and writes to the read-only flag.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    TW_OFF   = 2'b00,
    TW_CDOWN = 2'b01,
    TW_WDOG  = 2'b10,
    TW_RSVD  = 2'b11
  } tw_mode_e;

  localparam int unsigned DATA_W = 8;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_SRC   = 2'd1;
  localparam logic [1:0] A_COUNT = 2'd2;
  localparam logic [1:0] A_STAT  = 2'd3;

  localparam int unsigned B_PULSE = 7;
  localparam int unsigned B_WDF   = 7;
  localparam int unsigned B_CDF   = 6;
  localparam int unsigned B_WDE   = 2;
  localparam int unsigned B_CDE   = 1;
endpackage

// File: rtl/tw_regs.sv
module tw_regs
  import tw_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SRC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              cd_exp_i,
  input  logic              wd_exp_i,
  output tw_mode_e          mode_o,
  output logic              pulse_mode_o,
  output logic [SRC_W-1:0]  src_o,
  output logic              wd_en_o,
  output logic              cd_en_o,
  output logic              wd_flag_o,
  output logic              cd_flag_o,
  output logic              cnt_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  tw_mode_e         mode_q;
  logic             pulse_q, wd_en_q, cd_en_q, wd_flag_q, cd_flag_q;
  logic [SRC_W-1:0] src_q;
  logic             stat_rd, stat_wr, wdata_unused;

  assign wdata_unused = ^wdata_i;
  assign stat_rd  = rd_i && (addr_i == A_STAT);
  assign stat_wr  = wr_i && (addr_i == A_STAT);
  assign cnt_wr_o = wr_i && (addr_i == A_COUNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= TW_OFF;
      pulse_q <= 1'b0;
      src_q   <= '0;
      wd_en_q <= 1'b0;
      cd_en_q <= 1'b0;
    end else if (wr_i) begin
      unique case (addr_i)
        A_CTRL: begin
          mode_q  <= tw_mode_e'(wdata_i[2:1]);
          pulse_q <= wdata_i[B_PULSE];
        end
        A_SRC:  src_q <= wdata_i[SRC_W-1:0];
        A_STAT: begin
          wd_en_q <= wdata_i[B_WDE];
          cd_en_q <= wdata_i[B_CDE];
        end
        default: ;
      endcase
    end
  end

  // set has priority over clear so a coincident event is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_flag_q <= 1'b0;
      cd_flag_q <= 1'b0;
    end else begin
      if (wd_exp_i)     wd_flag_q <= 1'b1;
      else if (stat_rd) wd_flag_q <= 1'b0;
      if (cd_exp_i)                        cd_flag_q <= 1'b1;
      else if (stat_wr && !wdata_i[B_CDF]) cd_flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[B_PULSE] = pulse_q;
        rdata_o[2:1]     = mode_q;
      end
      A_SRC:   rdata_o[SRC_W-1:0] = src_q;
      A_COUNT: rdata_o[CNT_W-1:0] = cnt_i;
      A_STAT: begin
        rdata_o[B_WDF] = wd_flag_q;
        rdata_o[B_CDF] = cd_flag_q;
        rdata_o[B_WDE] = wd_en_q;
        rdata_o[B_CDE] = cd_en_q;
      end
      default: ;
    endcase
  end

  assign mode_o       = mode_q;
  assign pulse_mode_o = pulse_q;
  assign src_o        = src_q;
  assign wd_en_o      = wd_en_q;
  assign cd_en_o      = cd_en_q;
  assign wd_flag_o    = wd_flag_q;
  assign cd_flag_o    = cd_flag_q;

  p_wdf_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !wd_exp_i) |=> !wd_flag_q);
  p_wdf_ro_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_rd && !wd_exp_i) |=> $stable(wd_flag_q));
  p_wdf_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_exp_i |=> wd_flag_q);
  p_cdf_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cd_exp_i |=> cd_flag_q);
endmodule

// File: rtl/tw_core.sv
module tw_core
  import tw_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SRC_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [(1<<SRC_W)-1:0]  tick_i,
  input  logic [SRC_W-1:0]       src_i,
  input  tw_mode_e               mode_i,
  input  logic                   load_i,
  input  logic [CNT_W-1:0]       load_val_i,
  output logic [CNT_W-1:0]       cnt_o,
  output logic                   cd_exp_o,
  output logic                   wd_exp_o
);
  logic [CNT_W-1:0] cnt_q, reload_q;
  logic             halt_q, tick_sel, running, step, at_one;

  assign tick_sel = tick_i[src_i];
  assign running  = ((mode_i == TW_CDOWN) || (mode_i == TW_WDOG)) && !halt_q;
  assign step     = running && tick_sel && !load_i;
  // value 0 wraps through all ones, giving a full 2^CNT_W span
  assign at_one   = (cnt_q == CNT_W'(1));
  assign cd_exp_o = step && at_one && (mode_i == TW_CDOWN);
  assign wd_exp_o = step && at_one && (mode_i == TW_WDOG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
      halt_q   <= 1'b0;
    end else if (load_i) begin
      cnt_q    <= load_val_i;
      reload_q <= load_val_i;
      halt_q   <= 1'b0;
    end else if (cd_exp_o) begin
      cnt_q <= reload_q;
    end else if (wd_exp_o) begin
      cnt_q  <= '0;
      halt_q <= 1'b1;
    end else if (step) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
  p_off_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((mode_i == TW_OFF) || (mode_i == TW_RSVD)) && !load_i) |=> $stable(cnt_q));
  p_halt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !load_i) |=> $stable(cnt_q));
  p_no_tick_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_sel && !load_i) |=> $stable(cnt_q));
  p_one_expiry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cd_exp_o, wd_exp_o}));
endmodule

// File: rtl/tw_irq.sv
module tw_irq #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_mode_i,
  input  logic wd_flag_i,
  input  logic cd_flag_i,
  input  logic wd_en_i,
  input  logic cd_en_i,
  input  logic wd_exp_i,
  input  logic cd_exp_i,
  output logic irq_o
);
  logic level, fire, pulse;

  assign level = (wd_flag_i && wd_en_i) || (cd_flag_i && cd_en_i);
  assign fire  = (wd_exp_i && wd_en_i) || (cd_exp_i && cd_en_i);

  if (PULSE_LEN <= 1) begin : g_single
    logic p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) p_q <= 1'b0;
      else         p_q <= fire;
    end
    assign pulse = p_q;
  end else begin : g_count
    localparam int unsigned PW = $clog2(PULSE_LEN + 1);
    logic [PW-1:0] c_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               c_q <= '0;
      else if (fire)             c_q <= PW'(PULSE_LEN);
      else if (c_q != '0)        c_q <= c_q - PW'(1);
    end
    assign pulse = (c_q != '0);
  end

  assign irq_o = pulse_mode_i ? pulse : level;

  p_pulse_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_mode_i && fire) |=> (irq_o || !pulse_mode_i));
  p_pulse_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_mode_i && !irq_o && !fire) |=> (!irq_o || !pulse_mode_i));
  p_level_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_mode_i && !wd_flag_i && !cd_flag_i) |-> !irq_o);
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import tw_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned SRC_W     = 3,
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_wr_i,
  input  logic                  reg_rd_i,
  input  logic [1:0]            reg_addr_i,
  input  logic [7:0]            reg_wdata_i,
  output logic [7:0]            reg_rdata_o,
  input  logic [(1<<SRC_W)-1:0] tick_i,
  output logic                  irq_o
);
  tw_mode_e         mode;
  logic             pulse_mode, wd_en, cd_en, wd_flag, cd_flag, cnt_wr;
  logic             cd_exp, wd_exp;
  logic [SRC_W-1:0] src;
  logic [CNT_W-1:0] cnt;

  tw_regs #(.CNT_W(CNT_W), .SRC_W(SRC_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cnt_i(cnt), .cd_exp_i(cd_exp), .wd_exp_i(wd_exp),
    .mode_o(mode), .pulse_mode_o(pulse_mode), .src_o(src),
    .wd_en_o(wd_en), .cd_en_o(cd_en), .wd_flag_o(wd_flag), .cd_flag_o(cd_flag),
    .cnt_wr_o(cnt_wr), .rdata_o(reg_rdata_o)
  );

  tw_core #(.CNT_W(CNT_W), .SRC_W(SRC_W)) u_core (
    .clk_i, .rst_ni,
    .tick_i, .src_i(src), .mode_i(mode),
    .load_i(cnt_wr), .load_val_i(reg_wdata_i[CNT_W-1:0]),
    .cnt_o(cnt), .cd_exp_o(cd_exp), .wd_exp_o(wd_exp)
  );

  tw_irq #(.PULSE_LEN(PULSE_LEN)) u_irq (
    .clk_i, .rst_ni,
    .pulse_mode_i(pulse_mode), .wd_flag_i(wd_flag), .cd_flag_i(cd_flag),
    .wd_en_i(wd_en), .cd_en_i(cd_en), .wd_exp_i(wd_exp), .cd_exp_i(cd_exp),
    .irq_o
  );
endmodule

// File: tb/sim_tick_watchdog.sv
module sim_tick_watchdog;
  localparam int CNT_W = 4, SRC_W = 3, PULSE_LEN = 3;
  localparam int NSRC = 1 << SRC_W, SPAN = 1 << CNT_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_ni, wr, rd, irq;
  logic [1:0]      addr;
  logic [7:0]      wdata, rdata, d;
  logic [NSRC-1:0] tick;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  tick_watchdog #(.CNT_W(CNT_W), .SRC_W(SRC_W), .PULSE_LEN(PULSE_LEN)) u0 (
    .clk_i(clk), .rst_ni, .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tick_i(tick), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr_reg(input logic [1:0] a, input logic [7:0] v);
    wr = 1; addr = a; wdata = v;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    rd = 1; addr = a;
    #1 v = rdata;
    @(negedge clk);
    rd = 0;
  endtask

  task automatic pulse_tick(input int s);
    tick = '0; tick[s] = 1'b1;
    @(negedge clk);
    tick = '0;
  endtask

  task automatic tick_and_read(input int s, output logic [7:0] v);
    tick = '0; tick[s] = 1'b1; rd = 1; addr = 2'd3;
    #1 v = rdata;
    @(negedge clk);
    tick = '0; rd = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog timeout (all requirements) actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; wr = 0; rd = 0; addr = 0; wdata = 0; tick = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), d);
      chk("R1 reset reg", d, 0);
    end
    chk("R1 reset irq", irq, 0);

    wr_reg(2'd1, 8'h02);  // 1 Hz line

    // R4 R5 R6 exhaustive sweep of load values in both modes
    for (int m = 1; m <= 2; m++) begin
      for (int n = 0; n < SPAN; n++) begin
        int len;
        len = (n == 0) ? SPAN : n;
        wr_reg(2'd0, 8'(m << 1));
        wr_reg(2'd3, 8'h00);
        rd_reg(2'd3, d);
        wr_reg(2'd2, 8'(n));
        rd_reg(2'd2, d);
        chk("R4 load readback", d, n);
        for (int k = 1; k <= len; k++) begin
          int e;
          pulse_tick(2);
          rd_reg(2'd2, d);
          e = (k < len) ? (len - k) : ((m == 1) ? n : 0);
          chk((m == 1) ? "R5 countdown count" : "R6 watchdog count", d, e);
          if (k == len - 1) begin
            rd_reg(2'd3, d);
            chk("R4 no flag before expiry", d, 0);
          end
        end
        rd_reg(2'd3, d);
        chk((m == 1) ? "R5 countdown flag" : "R6 watchdog flag", d, (m == 1) ? 8'h40 : 8'h80);
        if (m == 2) begin
          pulse_tick(2);
          pulse_tick(2);
          rd_reg(2'd2, d);
          chk("R6 halted at zero", d, 0);
          rd_reg(2'd3, d);
          chk("R7 cleared by read", d, 0);
        end else begin
          int k2;
          rd_reg(2'd3, d);
          chk("R9 read keeps countdown flag", d, 8'h40);
          pulse_tick(2);
          rd_reg(2'd2, d);
          k2 = len - 1;
          chk("R5 periodic reload", d, (k2 == 0) ? n : k2);
        end
      end
    end

    // R2 stopped modes
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd2, 8'd5);
    pulse_tick(2);
    rd_reg(2'd2, d);
    chk("R2 mode 00 holds", d, 5);
    wr_reg(2'd0, 8'h06);
    pulse_tick(2);
    rd_reg(2'd2, d);
    chk("R2 mode 11 holds", d, 5);

    // R3 source selection
    wr_reg(2'd0, 8'h02);
    for (int s = 0; s < NSRC; s++) begin
      if (s != 2) begin
        pulse_tick(s);
        rd_reg(2'd2, d);
        chk("R3 other line ignored", d, 5);
      end
    end
    pulse_tick(2);
    rd_reg(2'd2, d);
    chk("R3 selected line counts", d, 4);
    wr_reg(2'd1, 8'h05);
    pulse_tick(2);
    pulse_tick(5);
    rd_reg(2'd2, d);
    chk("R3 reselected line", d, 3);
    wr_reg(2'd1, 8'h02);

    // R7 writes do not touch watchdog flag
    wr_reg(2'd0, 8'h04);
    wr_reg(2'd2, 8'd1);
    pulse_tick(2);
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd3, 8'h80);
    rd_reg(2'd3, d);
    chk("R7 write ignored", d, 8'h80);
    rd_reg(2'd3, d);
    chk("R7 clear on read", d, 0);

    // R8 read coincident with expiry
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd2, 8'd1);
    tick_and_read(2, d);
    chk("R8 pre-expiry read value", d, 0);
    rd_reg(2'd3, d);
    chk("R8 flag survives", d, 8'h80);
    rd_reg(2'd3, d);
    chk("R8 then clears", d, 0);

    // R9 countdown flag write semantics
    wr_reg(2'd0, 8'h02);
    wr_reg(2'd2, 8'd1);
    pulse_tick(2);
    wr_reg(2'd3, 8'h40);
    rd_reg(2'd3, d);
    chk("R9 write 1 keeps", d, 8'h40);
    wr_reg(2'd3, 8'h00);
    rd_reg(2'd3, d);
    chk("R9 write 0 clears", d, 0);

    // R10 level interrupt
    wr_reg(2'd0, 8'h04);
    wr_reg(2'd3, 8'h04);
    wr_reg(2'd2, 8'd1);
    chk("R10 idle irq", irq, 0);
    pulse_tick(2);
    chk("R10 wd level irq", irq, 1);
    rd_reg(2'd3, d);
    chk("R10 status", d, 8'h84);
    chk("R10 irq drops on clear", irq, 0);
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd2, 8'd1);
    pulse_tick(2);
    chk("R10 disabled no irq", irq, 0);
    rd_reg(2'd3, d);
    wr_reg(2'd0, 8'h02);
    wr_reg(2'd3, 8'h02);
    wr_reg(2'd2, 8'd1);
    pulse_tick(2);
    chk("R10 cd level irq", irq, 1);
    wr_reg(2'd3, 8'h02);
    chk("R10 cd irq clears", irq, 0);

    // R11 pulsed interrupt, countdown
    wr_reg(2'd0, 8'h82);
    wr_reg(2'd3, 8'h02);
    wr_reg(2'd2, 8'd2);
    pulse_tick(2);
    chk("R11 no pulse before expiry", irq, 0);
    pulse_tick(2);
    chk("R11 pulse cycle 1", irq, 1);
    for (int i = 2; i <= PULSE_LEN; i++) begin
      @(negedge clk);
      chk("R11 pulse held", irq, 1);
    end
    @(negedge clk);
    chk("R11 pulse ends with flag set", irq, 0);
    rd_reg(2'd3, d);
    chk("R11 flag still set", d, 8'h42);

    // R11 pulsed interrupt, watchdog, flag cleared mid-pulse
    wr_reg(2'd3, 8'h04);
    wr_reg(2'd0, 8'h84);
    wr_reg(2'd2, 8'd1);
    pulse_tick(2);
    chk("R11 wd pulse cycle 1", irq, 1);
    rd_reg(2'd3, d);
    chk("R11 wd status", d, 8'h84);
    for (int i = 2; i <= PULSE_LEN; i++) begin
      if (i > 2) @(negedge clk);
      chk("R11 pulse survives clear", irq, 1);
    end
    @(negedge clk);
    chk("R11 wd pulse ends", irq, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule